// File: doc/BRIEF.md
# Accumulator-Based Fractional Feedback Divider

This block divides the oscillator clock of an all-digital phase-locked loop by a fractional ratio. It holds a signed two's-complement accumulator that is updated on every oscillator clock. Two programmed step values set the update: a positive step, called N below, and a negative step, called the pull-back. The sign bit of the accumulator picks the step for the next update. The sign bit is also the divided output. The output pattern repeats every M = N − pullback oscillator cycles. In each repeat the output is low for exactly N cycles and high for M − N cycles. No separate modulus counter is needed, and the average ratio can be any fraction N/M.

The two step values come from a separate reprogram clock domain. A strobe on that clock captures both values into a holding pair and flips a request toggle. A synchroniser carries the toggle into the oscillator domain, where both values are loaded in the same cycle. At that load the accumulator restarts from zero, so every new ratio starts from the same phase.

Top module: `fdiv_top`

## Requirements
- R1: While `rst_n` is low on an oscillator edge, the accumulator clears to zero, so `div_out` is 0. The active steps take the values of the parameters `POS_INIT` (default 3) and `NEG_INIT` (default −5).
- R2: When the accumulator sign bit is 0, the next oscillator edge adds the negative step.
- R3: When the accumulator sign bit is 1, the next oscillator edge adds the positive step.
- R4: `div_out` is the sign (most significant) bit of the accumulator register. It changes only on oscillator edges.
- R5: With steps N > 0 and P < 0 and M = N − P, any M consecutive output cycles contain exactly N low cycles. Over K windows of M cycles there are K·N low cycles and K·(M−N) high cycles.
- R6: The accumulator is one bit wider than the steps, and no addition overflows it.
- R7: If `prog_valid` is high on a `prog_clk` rising edge, both values are captured together. With the default two synchroniser stages, they become active at the third oscillator edge after that `prog_clk` edge. That same edge clears the accumulator to zero. The two values never take effect separately.
- R8: A `prog_clk` edge with `prog_valid` low changes neither step, and the output pattern continues unchanged.
- R9: The accumulator always stays within [negative step, positive step − 1].
- R10: Programmed values must satisfy positive step > 0 and negative step < 0, both signed `STEP_W`-bit numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dco | input | 1 | Oscillator clock that steps the accumulator |
| rst_n | input | 1 | Active-low reset, synchronous on both clocks |
| prog_clk | input | 1 | Reprogram clock, asynchronous to clk_dco |
| prog_valid | input | 1 | Capture strobe sampled on prog_clk |
| prog_pos | input | STEP_W | New positive step N, signed |
| prog_neg | input | STEP_W | New negative step N−M, signed |
| div_out | output | 1 | Divided output, the accumulator sign bit |

## Verification
The divider runs with a default 3/8 ratio and with reprogrammed ratios 1/7, 127/128, 1/129 and 64/128. These cover a single low cycle per period, a single high cycle, a period that fills the accumulator range, and an even duty. Each value pair is compared every cycle against an integer model. A window count of low cycles shows that the long-run ratio is exact and separates errors in the step selection from errors in the sign-bit polarity. A strobe with valid low and different values shows that the steps are not loaded without a request. Back-to-back reprograms check the load cycle and the restart at zero.

// File: rtl/fdiv_pkg.sv
// Shared types of the fractional feedback divider.
// Assumes every programmed step fits a signed STEP_W-bit value.
package fdiv_pkg;
    parameter int STEP_W = 8;

    typedef logic signed [STEP_W-1:0] step_t;

    // The positive and negative steps always travel as one pair
    typedef struct packed {
        step_t pos;
        step_t neg;
    } step_pair_t;
endpackage

// File: rtl/fdiv_prog_capture.sv
// Reprogram-domain capture of the step pair.
// Stores both values on a strobed prog_clk edge and flips a request toggle.
// Assumes the caller leaves enough oscillator cycles between strobes for the toggle to cross.
module fdiv_prog_capture
    import fdiv_pkg::*;
#(
    parameter step_pair_t INIT = '0
) (
    input  logic       prog_clk,
    input  logic       rst_n,
    input  logic       prog_valid,
    input  step_t      prog_pos,
    input  step_t      prog_neg,
    output step_pair_t hold,
    output logic       req_tgl
);
    // Latch both steps at once and signal the request by a toggle
    always_ff @(posedge prog_clk) begin
        if (!rst_n) begin
            hold    <= INIT;
            req_tgl <= 1'b0;
        end else if (prog_valid) begin
            hold    <= '{pos: prog_pos, neg: prog_neg};
            req_tgl <= ~req_tgl;
        end
    end

    AST_STEP_SIGNS: assert property (@(posedge prog_clk) disable iff (!rst_n)
        prog_valid |-> ($signed(prog_pos) > 0 && $signed(prog_neg) < 0)); // R10
endmodule

// File: rtl/fdiv_cdc_pulse.sv
// Toggle synchroniser into the oscillator domain.
// Produces a one-cycle load pulse for each change of the incoming toggle.
// Assumes STAGES >= 2 and that the toggle changes no faster than STAGES+2 oscillator cycles.
module fdiv_cdc_pulse #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic load
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the toggle through the synchroniser and one edge-detect stage
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-2:0], tgl_in};
    end

    assign load = chain[CHAIN_W-1] ^ chain[CHAIN_W-2];

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load); // R7
endmodule

// File: rtl/fdiv_accum.sv
// Sign-steered accumulator of the fractional divider.
// Adds the positive step while negative and the negative step while non-negative.
// Assumes pos > 0 and neg < 0; a load swaps in both steps and restarts from zero.
module fdiv_accum
    import fdiv_pkg::*;
#(
    parameter step_pair_t INIT = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  step_pair_t hold,
    output logic       div_out
);
    localparam int ACC_W = STEP_W + 1;

    logic signed [ACC_W-1:0] acc;
    step_pair_t              act;
    step_t                   step_sel;
    logic signed [ACC_W:0]   sum_wide;

    // Pick the step from the current sign bit
    always_comb begin
        step_sel = acc[ACC_W-1] ? act.pos : act.neg;
        sum_wide = $signed({acc[ACC_W-1], acc}) + $signed({{2{step_sel[STEP_W-1]}}, step_sel});
    end

    // Step the accumulator or take a new pair and restart at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= INIT;
            acc <= '0;
        end else if (load) begin
            act <= hold;
            acc <= '0;
        end else begin
            acc <= sum_wide[ACC_W-1:0];
        end
    end

    assign div_out = acc[ACC_W-1];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        sum_wide[ACC_W] == sum_wide[ACC_W-1]); // R6
    AST_NONNEG_ADDS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !div_out) |=> (acc == $past(acc) + $signed($past(act.neg)))); // R2
    AST_NEG_ADDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && div_out) |=> (acc == $past(acc) + $signed($past(act.pos)))); // R3
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc == '0 && act == $past(hold))); // R7
    AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc >= $signed(act.neg) && acc < $signed(act.pos))); // R9
endmodule

// File: rtl/fdiv_top.sv
// Fractional feedback divider top: reprogram capture, toggle crossing, accumulator.
// Assumes prog_clk and clk_dco are unrelated and rst_n is applied on edges of both clocks.
module fdiv_top
    import fdiv_pkg::*;
#(
    parameter step_t POS_INIT    = 8'sd3,
    parameter step_t NEG_INIT    = -8'sd5,
    parameter int    SYNC_STAGES = 2
) (
    input  logic                     clk_dco,
    input  logic                     rst_n,
    input  logic                     prog_clk,
    input  logic                     prog_valid,
    input  logic signed [STEP_W-1:0] prog_pos,
    input  logic signed [STEP_W-1:0] prog_neg,
    output logic                     div_out
);
    localparam step_pair_t INIT_PAIR = '{pos: POS_INIT, neg: NEG_INIT};

    step_pair_t hold;
    logic       req_tgl;
    logic       load;

    fdiv_prog_capture #(.INIT(INIT_PAIR)) u_capture (
        .prog_clk  (prog_clk),
        .rst_n     (rst_n),
        .prog_valid(prog_valid),
        .prog_pos  (prog_pos),
        .prog_neg  (prog_neg),
        .hold      (hold),
        .req_tgl   (req_tgl)
    );

    fdiv_cdc_pulse #(.STAGES(SYNC_STAGES)) u_cdc (
        .clk   (clk_dco),
        .rst_n (rst_n),
        .tgl_in(req_tgl),
        .load  (load)
    );

    fdiv_accum #(.INIT(INIT_PAIR)) u_accum (
        .clk    (clk_dco),
        .rst_n  (rst_n),
        .load   (load),
        .hold   (hold),
        .div_out(div_out)
    );
endmodule

// File: tb/fdiv_top_tb.sv
`timescale 1ns/100ps
module fdiv_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_clk = 1'b0;
    logic prog_valid = 1'b0;
    logic signed [7:0] prog_pos = '0;
    logic signed [7:0] prog_neg = '0;
    logic div_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural model state
    int m_acc, m_pos, m_neg, q_pos, q_neg, pend;
    int low_cnt;

    always #2.5 clk = ~clk;   // 200 MHz

    fdiv_top u_dut (
        .clk_dco(clk), .rst_n(rst_n), .prog_clk(prog_clk), .prog_valid(prog_valid),
        .prog_pos(prog_pos), .prog_neg(prog_neg), .div_out(div_out)
    );

    // Model: steps per the requirements, load applied three edges after a strobe
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_pos = 3; m_neg = -5; pend = 0;
        end else if (pend == 1) begin
            m_acc = 0; m_pos = q_pos; m_neg = q_neg; pend = 0;
        end else begin
            if (pend > 1) pend = pend - 1;
            m_acc = m_acc + ((m_acc < 0) ? m_pos : m_neg);
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Sample now, compare against the model, then move to the next negedge
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            check(div_out == (m_acc < 0), "R4 R2 R3 output vs model", div_out, m_acc < 0);
            if (!div_out) low_cnt++;
            @(negedge clk);
        end
    endtask

    task automatic prog(input bit valid, input int p, input int n);
        prog_valid = valid; prog_pos = 8'(p); prog_neg = 8'(n);
        #0.5 prog_clk = 1'b1;
        #0.5 prog_clk = 1'b0;
        prog_valid = 1'b0;
        if (valid && rst_n) begin q_pos = p; q_neg = n; pend = 3; end
    endtask

    // Reprogram, let the old ratio run out, then count lows over K windows
    task automatic ratio(input int p, input int n, input int k);
        int m;
        m = p - n;
        prog(1'b1, p, n);
        run(3);
        check(div_out == 1'b0, "R7 restart at zero", div_out, 0);
        low_cnt = 0;
        run(k * m);
        check(low_cnt == k * p, "R5 low count over windows", low_cnt, k * p);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        prog(1'b0, 0, 0);
        @(negedge clk);
        prog(1'b0, 0, 0);
        repeat (3) @(negedge clk);
        check(div_out == 1'b0, "R1 reset output", div_out, 0);
        rst_n = 1'b1;
        // R1 R5: default 3/8 from reset
        low_cnt = 0;
        run(80);
        check(low_cnt == 30, "R1 R5 default ratio", low_cnt, 30);
        // R8: strobe low must leave the pattern alone
        prog(1'b0, 1, -100);
        run(5);
        low_cnt = 0;
        run(40);
        check(low_cnt == 15, "R8 ignored strobe keeps ratio", low_cnt, 15);
        // R7 R9 R6: several ratios, including range limits
        ratio(1, -6, 6);
        ratio(127, -1, 3);
        ratio(1, -128, 2);
        ratio(64, -64, 2);
        // R7: back-to-back requests after each has crossed
        prog(1'b1, 2, -3);
        run(6);
        ratio(5, -2, 10);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule